// File: doc/BRIEF.md
# Clock Output Enable and Stop Controller

This block sits between the synthesized clocks of a multi-output clock generator and its output pads. For each output it decides whether the output toggles, is held in a parked state, or is switched off. It also captures the frequency-select and CPU-port straps while power-good is asserted. The raw source clocks are given to the block as sampled levels on a fast control clock `clk_i`. Each output lane updates its state only on a control edge where its own source is low. Because of this, a lane never cuts a high phase short.

There are 19 lanes, at fixed indices. Lanes 0..7 are differential SRC outputs. Lane 7 is shared and can instead carry a CPU-rate clock. Lanes 8..9 are differential CPU outputs and lane 10 is the differential 96 MHz display clock. Lanes 11..12 are free-running-capable PCI outputs, and lanes 13..16 are plain PCI outputs. Lane 17 is the 48 MHz USB output and lane 18 is the reference output. Lanes 11..18 are single-ended.

Each lane is a run, hold or off selector. Power-down has the highest priority, then stop, then the individual enable. The stop and power-down pins pass through a two-flop synchronizer before they are used.

Top module: `clk_out_ctrl`

## Requirements
- R1: A lane whose `out_en_i` bit is 1, with no stop and no power-down, follows its source clock on `clk_o`. Its true-leg enable is 1, and its complement-leg enable is 1 only on differential lanes (0..10). A lane whose bit is 0 has `clk_o`, `oe_t_o` and `oe_c_o` all at 0.
- R2: For SRC lanes 0..7 and PCI lanes 11..12, `stop_mask_i` bit j (j = lane for SRC, 8 + lane − 11 for lanes 11..12) set to 1 makes the lane stop while `pci_stop_ni` is 0. With the bit at 0 the lane keeps running.
- R3: For CPU lanes 8..9, `cpu_stop_en_i` bit (lane − 8) set to 1 makes the lane stop while `cpu_stop_ni` is 0. With the bit at 0 the lane keeps running.
- R4: PCI lanes 13..16 always stop while `pci_stop_ni` is 0. `all_stop_i` = 1 stops every SRC and PCI lane (0..7, 11..16) whatever the mask. Lanes 8..10, 17 and 18 are not affected by the PCI stop pin or by `all_stop_i`.
- R5: A stopped differential lane drives its true leg high (`clk_o`=1, `oe_t_o`=1) when `stop_drive_i` is 1, and floats it (`clk_o`=0, `oe_t_o`=0) when `stop_drive_i` is 0. Its complement enable is always 0. A stopped single-ended lane is driven low.
- R6: `pd_i` = 1 puts every lane into the stopped state of R5, including free-running and disabled lanes. Power-down outranks stop, and stop outranks the enable bit.
- R7: A lane changes state only at a control edge where its selected source is sampled low. While the source stays high, `clk_o` stays high.
- R8: A change on `pd_i`, `cpu_stop_ni` or `pci_stop_ni` before control edge t can change a lane no earlier than edge t+2.
- R9: `fs_o` loads `fs_strap_i` on every control edge while `pwrgd_ni` is 0, and holds afterwards.
- R10: `itp_sel_o` loads `itp_strap_i` in the same window as R9. When it is 1, lane 7 takes `cpu_alt_clk_i` and obeys the CPU stop pin through `cpu_stop_en_i` bit 2. When it is 0, lane 7 takes its SRC source and obeys `stop_mask_i` bit 7 with the PCI stop pin.
- R11: In reset every lane is off (all outputs 0), `fs_o` is 0 and `itp_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | control clock on which sources are sampled |
| rst_ni | input | 1 | asynchronous reset, active low |
| src_clk_i | input | 19 | source clock level per lane |
| cpu_alt_clk_i | input | 1 | CPU-rate source for shared lane 7 |
| out_en_i | input | 19 | per-lane enable |
| stop_mask_i | input | 10 | PCI-stop susceptibility for lanes 0..7, 11..12 |
| cpu_stop_en_i | input | 3 | CPU-stop susceptibility for lanes 8, 9 and shared lane 7 |
| all_stop_i | input | 1 | stop every SRC and PCI lane |
| stop_drive_i | input | 1 | parked differential true leg driven high |
| cpu_stop_ni | input | 1 | CPU stop pin, active low |
| pci_stop_ni | input | 1 | PCI/SRC stop pin, active low |
| pd_i | input | 1 | power-down, active high |
| pwrgd_ni | input | 1 | power-good, active low, strap capture window |
| fs_strap_i | input | 3 | frequency-select straps |
| itp_strap_i | input | 1 | shared-lane routing strap |
| clk_o | output | 19 | gated clock level per lane |
| oe_t_o | output | 19 | true-leg drive enable |
| oe_c_o | output | 19 | complement-leg drive enable |
| fs_o | output | 3 | captured frequency select |
| itp_sel_o | output | 1 | captured shared-lane routing |

## Verification
A lane register left in the wrong state shows up at once at the ports. The pair `oe_t_o`/`oe_c_o` of that lane disagrees with the run, hold or off pattern on the very next sample. A wrong `clk_o` level shows within one half period of the source. A synchronizer stage that is missing or extra moves the first changed lane by one control cycle, and this is seen against the per-cycle model. A strap register that reloads outside the power-good window changes `fs_o` or the clock routed on lane 7 on the cycle after the strap pins move.

// File: rtl/clk_out_ctrl_pkg.sv
package clk_out_ctrl_pkg;
  typedef enum logic [1:0] {
    LANE_OFF  = 2'd0,
    LANE_RUN  = 2'd1,
    LANE_HOLD = 2'd2
  } lane_mode_e;
endpackage

// File: rtl/clk_out_ctrl_sync.sv
module clk_out_ctrl_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/clk_out_ctrl_strap.sv
module clk_out_ctrl_strap #(
  parameter int FS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwrgd_ni,
  input  logic [FS_W-1:0] fs_i,
  input  logic            itp_i,
  output logic [FS_W-1:0] fs_o,
  output logic            itp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_o  <= '0;
      itp_o <= 1'b0;
    end else if (!pwrgd_ni) begin
      fs_o  <= fs_i;
      itp_o <= itp_i;
    end
  end
endmodule

// File: rtl/clk_out_ctrl_lane.sv
module clk_out_ctrl_lane
  import clk_out_ctrl_pkg::*;
#(
  parameter bit DIFF = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       src_i,
  input  lane_mode_e want_i,
  input  logic       drive_i,
  output logic       clk_o,
  output logic       oe_t_o,
  output logic       oe_c_o
);
  lane_mode_e mode_q;

  // state moves only while the source is low: no runt high phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= LANE_OFF;
    else if (!src_i) mode_q <= want_i;
  end

  always_comb begin
    clk_o  = 1'b0;
    oe_t_o = 1'b0;
    oe_c_o = 1'b0;
    unique case (mode_q)
      LANE_RUN: begin
        clk_o  = src_i;
        oe_t_o = 1'b1;
        oe_c_o = DIFF;
      end
      LANE_HOLD: begin
        clk_o  = DIFF & drive_i;
        oe_t_o = DIFF ? drive_i : 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/clk_out_ctrl.sv
module clk_out_ctrl
  import clk_out_ctrl_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_CPU  = 2,
  parameter int N_PCIF = 2,
  parameter int N_PCI  = 4,
  parameter int FS_W   = 3,
  localparam int CPU_BASE  = N_SRC,
  localparam int DOT_IDX   = CPU_BASE + N_CPU,
  localparam int PCIF_BASE = DOT_IDX + 1,
  localparam int PCI_BASE  = PCIF_BASE + N_PCIF,
  localparam int N_OUT     = PCI_BASE + N_PCI + 2,
  localparam int N_MASK    = N_SRC + N_PCIF,
  localparam int N_CSTOP   = N_CPU + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_OUT-1:0]   src_clk_i,
  input  logic               cpu_alt_clk_i,
  input  logic [N_OUT-1:0]   out_en_i,
  input  logic [N_MASK-1:0]  stop_mask_i,
  input  logic [N_CSTOP-1:0] cpu_stop_en_i,
  input  logic               all_stop_i,
  input  logic               stop_drive_i,
  input  logic               cpu_stop_ni,
  input  logic               pci_stop_ni,
  input  logic               pd_i,
  input  logic               pwrgd_ni,
  input  logic [FS_W-1:0]    fs_strap_i,
  input  logic               itp_strap_i,
  output logic [N_OUT-1:0]   clk_o,
  output logic [N_OUT-1:0]   oe_t_o,
  output logic [N_OUT-1:0]   oe_c_o,
  output logic [FS_W-1:0]    fs_o,
  output logic               itp_sel_o
);
  localparam int SHARED_IDX = N_SRC - 1;

  logic [2:0] pins_s;
  logic pd_s, cpu_stop_s, pci_stop_s;

  clk_out_ctrl_sync #(.W(3), .RST_VAL(3'b011)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pd_i, cpu_stop_ni, pci_stop_ni}),
    .q_o    (pins_s)
  );

  assign pd_s       = pins_s[2];
  assign cpu_stop_s = ~pins_s[1];
  assign pci_stop_s = ~pins_s[0];

  clk_out_ctrl_strap #(.FS_W(FS_W)) u_strap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwrgd_ni (pwrgd_ni),
    .fs_i     (fs_strap_i),
    .itp_i    (itp_strap_i),
    .fs_o     (fs_o),
    .itp_o    (itp_sel_o)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_lane
    localparam bit DIFF = (k <= DOT_IDX);
    logic       stop_k;
    logic       src_k;
    lane_mode_e want_k;

    if (k == SHARED_IDX) begin : g_shared
      assign src_k  = itp_sel_o ? cpu_alt_clk_i : src_clk_i[k];
      assign stop_k = itp_sel_o ? (cpu_stop_s & cpu_stop_en_i[N_CPU])
                                : ((pci_stop_s & stop_mask_i[k]) | all_stop_i);
    end else if (k < CPU_BASE) begin : g_src
      assign src_k  = src_clk_i[k];
      assign stop_k = (pci_stop_s & stop_mask_i[k]) | all_stop_i;
    end else if (k < DOT_IDX) begin : g_cpu
      assign src_k  = src_clk_i[k];
      assign stop_k = cpu_stop_s & cpu_stop_en_i[k-CPU_BASE];
    end else if (k >= PCIF_BASE && k < PCI_BASE) begin : g_pcif
      assign src_k  = src_clk_i[k];
      assign stop_k = (pci_stop_s & stop_mask_i[N_SRC+k-PCIF_BASE]) | all_stop_i;
    end else if (k >= PCI_BASE && k < PCI_BASE + N_PCI) begin : g_pci
      assign src_k  = src_clk_i[k];
      assign stop_k = pci_stop_s | all_stop_i;
    end else begin : g_fixed
      assign src_k  = src_clk_i[k];
      assign stop_k = 1'b0;
    end

    // priority: power-down, then stop, then enable
    always_comb begin
      if (pd_s || stop_k)   want_k = LANE_HOLD;
      else if (out_en_i[k]) want_k = LANE_RUN;
      else                  want_k = LANE_OFF;
    end

    clk_out_ctrl_lane #(.DIFF(DIFF)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   (src_k),
      .want_i  (want_k),
      .drive_i (stop_drive_i),
      .clk_o   (clk_o[k]),
      .oe_t_o  (oe_t_o[k]),
      .oe_c_o  (oe_c_o[k])
    );
  end
endmodule

// File: rtl/clk_out_ctrl_chk.sv
module clk_out_ctrl_chk #(
  parameter int N_SRC  = 8,
  parameter int N_CPU  = 2,
  parameter int N_PCIF = 2,
  parameter int N_PCI  = 4,
  parameter int FS_W   = 3,
  localparam int DOT_IDX = N_SRC + N_CPU,
  localparam int N_OUT   = DOT_IDX + 1 + N_PCIF + N_PCI + 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_OUT-1:0] src_clk_i,
  input logic             stop_drive_i,
  input logic             pd_i,
  input logic             pwrgd_ni,
  input logic [N_OUT-1:0] clk_o,
  input logic [N_OUT-1:0] oe_t_o,
  input logic [N_OUT-1:0] oe_c_o,
  input logic [FS_W-1:0]  fs_o,
  input logic             itp_sel_o
);
  localparam int SHARED_IDX = N_SRC - 1;

  // R5: complement leg never driven without the true leg
  assert_comp_needs_true_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_c_o & ~oe_t_o) == '0);

  // R1: a high clock level is never left floating
  assert_clk_driven_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_o & ~oe_t_o) == '0);

  // R9: straps stay put outside the power-good window
  assert_strap_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrgd_ni && $past(pwrgd_ni)) |-> ($stable(fs_o) && $stable(itp_sel_o)));

  for (genvar k = 0; k < N_OUT; k++) begin : g_lane_chk
    if (k != SHARED_IDX) begin : g_runt
      // R7: a high phase is never cut short
      assert_no_runt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_clk_i[k] && $past(src_clk_i[k]) && $past(clk_o[k]) && $stable(stop_drive_i))
          |-> clk_o[k]);
    end
    if (k > DOT_IDX) begin : g_se
      // R6: power-down parks single-ended lanes low, driven
      assert_pd_park_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(pd_i, 3) && !$past(src_clk_i[k])) |-> (!clk_o[k] && oe_t_o[k]));
      // R1: single-ended lanes never drive a complement
      assert_se_no_comp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_c_o[k]);
    end
  end
endmodule

bind clk_out_ctrl clk_out_ctrl_chk #(
  .N_SRC(N_SRC), .N_CPU(N_CPU), .N_PCIF(N_PCIF), .N_PCI(N_PCI), .FS_W(FS_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .src_clk_i    (src_clk_i),
  .stop_drive_i (stop_drive_i),
  .pd_i         (pd_i),
  .pwrgd_ni     (pwrgd_ni),
  .clk_o        (clk_o),
  .oe_t_o       (oe_t_o),
  .oe_c_o       (oe_c_o),
  .fs_o         (fs_o),
  .itp_sel_o    (itp_sel_o)
);

// File: tb/clk_out_ctrl_tb.sv
module clk_out_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_OUT   = 19;
  localparam int DOT_IDX = 10;
  localparam int SHARED  = 7;
  localparam int REF_IDX = 18;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic [N_OUT-1:0]  src_clk_i;
  logic              cpu_alt_clk_i;
  logic [N_OUT-1:0]  out_en_i;
  logic [9:0]        stop_mask_i;
  logic [2:0]        cpu_stop_en_i;
  logic              all_stop_i, stop_drive_i, cpu_stop_ni, pci_stop_ni, pd_i, pwrgd_ni;
  logic [2:0]        fs_strap_i;
  logic              itp_strap_i;
  logic [N_OUT-1:0]  clk_o, oe_t_o, oe_c_o;
  logic [2:0]        fs_o;
  logic              itp_sel_o;

  clk_out_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_clk_i(src_clk_i), .cpu_alt_clk_i(cpu_alt_clk_i),
    .out_en_i(out_en_i), .stop_mask_i(stop_mask_i), .cpu_stop_en_i(cpu_stop_en_i),
    .all_stop_i(all_stop_i), .stop_drive_i(stop_drive_i), .cpu_stop_ni(cpu_stop_ni),
    .pci_stop_ni(pci_stop_ni), .pd_i(pd_i), .pwrgd_ni(pwrgd_ni), .fs_strap_i(fs_strap_i),
    .itp_strap_i(itp_strap_i), .clk_o(clk_o), .oe_t_o(oe_t_o), .oe_c_o(oe_c_o),
    .fs_o(fs_o), .itp_sel_o(itp_sel_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int    checks = 0;
  int    errors = 0;
  string tag = "R11";

  // source waveform state; index N_OUT is the CPU-rate alternate
  int hcnt [N_OUT+1];
  bit force_hi [N_OUT];

  // behavioural model: 0 off, 1 run, 2 hold
  int       mode_m [N_OUT];
  bit       sp1 [3];
  bit       sp2 [3];  // [0] pd, [1] cpu stop, [2] pci stop (active high)
  bit [2:0] fs_m;
  bit       itp_m;

  function automatic bit sel_src(int k);
    if (k == SHARED && itp_m) return cpu_alt_clk_i;
    return src_clk_i[k];
  endfunction

  function automatic bit lane_stops(int k);
    bit pci = sp2[2];
    bit cpu = sp2[1];
    if (k == SHARED && itp_m) return cpu && cpu_stop_en_i[2];
    if (k <= 7)               return all_stop_i || (pci && stop_mask_i[k]);
    if (k == 8 || k == 9)     return cpu && cpu_stop_en_i[k-8];
    if (k == 11 || k == 12)   return all_stop_i || (pci && stop_mask_i[k-3]);
    if (k >= 13 && k <= 16)   return all_stop_i || pci;
    return 1'b0;
  endfunction

  task automatic model_edge();
    int want [N_OUT];
    for (int k = 0; k < N_OUT; k++) begin
      if (sp2[0] || lane_stops(k)) want[k] = 2;
      else                         want[k] = out_en_i[k] ? 1 : 0;
    end
    for (int k = 0; k < N_OUT; k++)
      if (!sel_src(k)) mode_m[k] = want[k];
    sp2 = sp1;
    sp1[0] = pd_i; sp1[1] = !cpu_stop_ni; sp1[2] = !pci_stop_ni;
    if (!pwrgd_ni) begin
      fs_m  = fs_strap_i;
      itp_m = itp_strap_i;
    end
  endtask

  task automatic compare();
    logic [N_OUT-1:0] ec, et, eo;
    for (int k = 0; k < N_OUT; k++) begin
      bit diff = (k <= DOT_IDX);
      ec[k] = 0; et[k] = 0; eo[k] = 0;
      if (mode_m[k] == 1) begin
        ec[k] = sel_src(k); et[k] = 1; eo[k] = diff;
      end else if (mode_m[k] == 2) begin
        ec[k] = diff & stop_drive_i; et[k] = diff ? stop_drive_i : 1'b1;
      end
    end
    checks++;
    if (clk_o !== ec || oe_t_o !== et || oe_c_o !== eo || fs_o !== fs_m || itp_sel_o !== itp_m) begin
      errors++;
      $display("FAIL %s cycle: clk=%h/%h oe_t=%h/%h oe_c=%h/%h fs=%0d/%0d itp=%0d/%0d (actual/expected)",
               tag, clk_o, ec, oe_t_o, et, oe_c_o, eo, fs_o, fs_m, itp_sel_o, itp_m);
    end
  endtask

  task automatic advance_src();
    for (int k = 0; k <= N_OUT; k++) begin
      int hp = (k == N_OUT) ? 2 : 1 + (k % 4);
      hcnt[k]++;
      if (k < N_OUT && force_hi[k]) src_clk_i[k] = 1'b1;
      else if (hcnt[k] >= hp) begin
        hcnt[k] = 0;
        if (k == N_OUT) cpu_alt_clk_i = ~cpu_alt_clk_i;
        else            src_clk_i[k] = ~src_clk_i[k];
      end
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk_i);
      model_edge();
      compare();
      advance_src();
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 0; src_clk_i = '0; cpu_alt_clk_i = 0; out_en_i = '1; stop_mask_i = '0;
    cpu_stop_en_i = 3'b111; all_stop_i = 0; stop_drive_i = 0; cpu_stop_ni = 1;
    pci_stop_ni = 1; pd_i = 0; pwrgd_ni = 1; fs_strap_i = 3'b000; itp_strap_i = 0;
    for (int k = 0; k < N_OUT; k++) begin mode_m[k] = 0; force_hi[k] = 0; end
    for (int k = 0; k <= N_OUT; k++) hcnt[k] = 0;
    for (int i = 0; i < 3; i++) begin sp1[i] = 0; sp2[i] = 0; end
    fs_m = 0; itp_m = 0;

    repeat (3) @(negedge clk_i);
    chk("R11", {13'd0, clk_o}, 32'd0, "clk in reset");
    chk("R11", {13'd0, oe_t_o | oe_c_o}, 32'd0, "drive in reset");
    chk("R11", {28'd0, itp_sel_o, fs_o}, 32'd0, "straps in reset");
    rst_ni = 1;

    tag = "R9";
    pwrgd_ni = 0; fs_strap_i = 3'b101; step(3);
    pwrgd_ni = 1; fs_strap_i = 3'b010; step(4);
    chk("R9", fs_o, 3'b101, "fs held after window");

    tag = "R1";
    step(20);
    chk("R1", oe_c_o[DOT_IDX], 1, "display complement driven");
    chk("R1", {oe_t_o[REF_IDX], oe_c_o[REF_IDX]}, 2'b10, "ref legs");
    out_en_i = 19'h7FFF7; step(12);
    chk("R1", {clk_o[3], oe_t_o[3], oe_c_o[3]}, 3'b000, "disabled lane off");
    out_en_i = '1; step(12);

    tag = "R2";
    stop_mask_i = 10'b10_0000_0001; pci_stop_ni = 0; step(12);
    chk("R2", {oe_t_o[0], oe_c_o[0]}, 2'b00, "masked src parked floating");
    chk("R2", oe_c_o[1], 1, "unmasked src runs");
    chk("R2", {clk_o[12], oe_t_o[12]}, 2'b01, "masked pcif parked low");
    chk("R2", oe_t_o[11], 1, "unmasked pcif driven");
    tag = "R4";
    chk("R4", {clk_o[13], oe_t_o[13]}, 2'b01, "pci lane stops on pin");
    pci_stop_ni = 1; step(12);
    chk("R2", oe_c_o[0], 1, "src resumes");

    tag = "R8";
    stop_mask_i = 10'b00_0000_0001; pci_stop_ni = 0; step(2);
    chk("R8", oe_c_o[0], 1, "no change within two edges");
    step(10);
    chk("R8", oe_c_o[0], 0, "stop applied after sync");
    pci_stop_ni = 1; stop_mask_i = '0; step(12);

    tag = "R3";
    cpu_stop_en_i = 3'b001; cpu_stop_ni = 0; step(12);
    chk("R3", oe_c_o[8], 0, "stoppable cpu parked");
    chk("R3", oe_c_o[9], 1, "non-stoppable cpu runs");
    cpu_stop_ni = 1; step(12);

    tag = "R4";
    all_stop_i = 1; step(12);
    chk("R4", oe_c_o[2], 0, "global stop ignores mask");
    chk("R4", {clk_o[14], oe_t_o[14]}, 2'b01, "global stop parks pci");
    chk("R4", {oe_c_o[8], oe_c_o[DOT_IDX], oe_t_o[17]}, 3'b111, "cpu/display/usb unaffected");
    all_stop_i = 0; step(12);

    tag = "R5";
    stop_drive_i = 1; stop_mask_i = '1; pci_stop_ni = 0; step(12);
    chk("R5", {clk_o[0], oe_t_o[0], oe_c_o[0]}, 3'b110, "parked true leg driven high");
    chk("R5", {clk_o[12], oe_t_o[12], oe_c_o[12]}, 3'b010, "parked single-ended low");
    pci_stop_ni = 1; stop_mask_i = '0; stop_drive_i = 0; step(12);

    tag = "R6";
    out_en_i = 19'h7FFF7; stop_drive_i = 1; pd_i = 1; step(12);
    chk("R6", {clk_o[3], oe_t_o[3]}, 2'b11, "power-down outranks disable");
    chk("R6", {clk_o[REF_IDX], oe_t_o[REF_IDX]}, 2'b01, "free-running lane parked");
    chk("R6", {13'd0, oe_c_o}, 32'd0, "no complement under power-down");
    step(3);
    chk("R6", clk_o[REF_IDX], 0, "ref stays parked");
    pd_i = 0; stop_drive_i = 0; out_en_i = '1; step(12);

    tag = "R10";
    pwrgd_ni = 0; itp_strap_i = 1; step(2);
    pwrgd_ni = 1; itp_strap_i = 0; step(4);
    chk("R10", itp_sel_o, 1, "routing strap latched");
    cpu_stop_en_i = 3'b100; cpu_stop_ni = 0; step(12);
    chk("R10", oe_c_o[SHARED], 0, "shared lane obeys cpu stop");
    cpu_stop_ni = 1; step(12);
    stop_mask_i = 10'b00_1000_0000; pci_stop_ni = 0; step(12);
    chk("R10", oe_c_o[SHARED], 1, "shared lane ignores pci stop");
    chk("R10", oe_c_o[6], 1, "src6 unmasked");
    pci_stop_ni = 1; stop_mask_i = '0; step(12);

    tag = "R7";
    force_hi[13] = 1; step(6);
    all_stop_i = 1; step(6);
    chk("R7", {clk_o[13], oe_t_o[13]}, 2'b11, "high phase not cut");
    force_hi[13] = 0; step(12);
    chk("R7", {clk_o[13], oe_t_o[13]}, 2'b01, "parks after source low");
    all_stop_i = 0; step(12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule